// File: doc/BRIEF.md
# Address Window Decoder with Reserved Top-of-Memory Windows

This block decodes the address of each bus transfer in a 32-bit space and picks the slave that owns it. Every slave region is a power-of-two number of bytes, and its base is a multiple of its own size. Because of that rule, a region test is one masked equality compare. Two windows at the top of memory are fixed: a 1 MiB I/O window and a 4 KiB configuration window inside it. A hit in either window wins over any slave region that overlaps the same addresses.

The result is registered. One cycle after a valid address is presented, exactly one of these outputs is high: one select line, the I/O hit, the configuration hit, or the no-slave flag. The parameter `ALT_MAP` picks between two fixed region layouts. One layout leaves room for a small boot area low in memory. The other gives the lowest 2 GiB to RAM.

Top module: `addr_window_decoder`

## Requirements
- R1: Each slave region covers 2^k bytes starting at a base that is a multiple of 2^k, and misaligned parameters are rejected when the design is elaborated. An access selects slave i at the first and at the last byte of its span, and at no address outside it.
- R2: With `ALT_MAP`=0 the slave regions are as follows, with `slv_sel` bit i selecting slave i: slave 0 at 0x00000000 (512 MiB), slave 1 at 0x40000000 (1 GiB), slave 2 at 0x80000000 (256 MiB), slave 3 at 0x90000000 (256 MiB), slave 4 at 0xF0000000 (256 MiB).
- R3: With `ALT_MAP`=1 the slave regions are: slave 0 at 0x00000000 (2 GiB), slave 1 at 0x80000000 (1 GiB), slave 2 at 0xC0000000, slave 3 at 0xD0000000, slave 4 at 0xE0000000 (each 256 MiB).
- R4: A valid access in 0xFFFFF000..0xFFFFFFFF raises `cfg_hit` only. `io_hit` stays low and every select stays low.
- R5: A valid access in 0xFFF00000..0xFFFFEFFF raises `io_hit` only. No select is raised, even where a slave region overlaps the window.
- R6: A valid access that falls in no slave region and in neither window raises `no_slave`, and every select stays low.
- R7: While `req_valid` is low, all outputs are low whatever the address.
- R8: Outputs reflect the inputs sampled at the previous rising clock edge, and they are all low during and right after reset.
- R9: After a valid access, exactly one of the five select bits, `io_hit`, `cfg_hit` and `no_slave` is high. At most one select bit is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address below is a live transfer |
| req_addr | input | 32 | Transfer byte address |
| slv_sel | output | 5 | One-hot slave select, bit i for slave i |
| io_hit | output | 1 | Access lies in the I/O window, outside the configuration window |
| cfg_hit | output | 1 | Access lies in the configuration window |
| no_slave | output | 1 | Valid access matched nothing |

## Verification
Two instances, one built with each layout, receive the same address stream. Directed addresses land on the first and last byte of every region and window. These show whether a mask is one bit too wide or too narrow, and whether the configuration window, rather than the I/O window, wins at 0xFFFFF000. Addresses in the gaps, and in the slave region that lies under the I/O window, show whether shadowing is applied and whether the no-slave flag appears. Random addresses, a quarter of them forced into the top megabyte, test the one-outcome rule. Cycles with the strobe low, carrying addresses that would otherwise hit, show that the strobe gates every output.

// File: rtl/adec_pkg.sv
package adec_pkg;

  localparam int unsigned NUM_SLV = 5;
  localparam int unsigned AW      = 32;

  // Mask that keeps the address bits above a 2^lg byte span.
  function automatic logic [AW-1:0] span_mask(input int unsigned lg);
    logic [AW:0] low_ones;
    low_ones = ({{AW{1'b0}}, 1'b1} << lg) - {{AW{1'b0}}, 1'b1};
    return ~low_ones[AW-1:0];
  endfunction

  function automatic logic in_span(input logic [AW-1:0] a,
                                   input logic [AW-1:0] base,
                                   input int unsigned lg);
    return ((a ^ base) & span_mask(lg)) == '0;
  endfunction

  function automatic logic base_aligned(input logic [AW-1:0] base,
                                        input int unsigned lg);
    return (base & ~span_mask(lg)) == '0;
  endfunction

  function automatic logic [AW-1:0] map_base(input bit alt, input int unsigned idx);
    logic [AW-1:0] b;
    if (!alt) begin
      case (idx)
        0: b = 32'h0000_0000;
        1: b = 32'h4000_0000;
        2: b = 32'h8000_0000;
        3: b = 32'h9000_0000;
        default: b = 32'hF000_0000;
      endcase
    end else begin
      case (idx)
        0: b = 32'h0000_0000;
        1: b = 32'h8000_0000;
        2: b = 32'hC000_0000;
        3: b = 32'hD000_0000;
        default: b = 32'hE000_0000;
      endcase
    end
    return b;
  endfunction

  function automatic int unsigned map_log2(input bit alt, input int unsigned idx);
    int unsigned lg;
    if (!alt) begin
      case (idx)
        0: lg = 29;
        1: lg = 30;
        default: lg = 28;
      endcase
    end else begin
      case (idx)
        0: lg = 31;
        1: lg = 30;
        default: lg = 28;
      endcase
    end
    return lg;
  endfunction

endpackage

// File: rtl/adec_window.sv
module adec_window #(
  parameter logic [31:0] BASE = 32'h0,
  parameter int unsigned LOG2 = 12
) (
  input  logic [31:0] addr,
  output logic        hit
);
  import adec_pkg::*;

  // R1: a base that is not a multiple of its span is a build error
  initial begin
    assert (base_aligned(BASE, LOG2))
      else $error("adec_window: base %h not aligned to 2^%0d", BASE, LOG2);
  end

  assign hit = in_span(addr, BASE, LOG2);

endmodule

// File: rtl/adec_resolve.sv
module adec_resolve #(
  parameter int unsigned N = 5
) (
  input  logic         valid,
  input  logic [N-1:0] raw_hit,
  input  logic         io_win,
  input  logic         cfg_win,
  output logic [N-1:0] sel_nxt,
  output logic         io_nxt,
  output logic         cfg_nxt,
  output logic         none_nxt
);
  logic [N-1:0] below;  // some lower-index slave already matched
  logic [N-1:0] pick;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_prio
      if (i == 0) begin : g_first
        assign below[i] = 1'b0;
      end else begin : g_rest
        assign below[i] = below[i-1] | raw_hit[i-1];
      end
      assign pick[i] = raw_hit[i] & ~below[i];
    end
  endgenerate

  logic ordinary;
  assign ordinary = valid & ~io_win;

  assign sel_nxt  = ordinary ? pick : '0;
  assign cfg_nxt  = valid & cfg_win;
  assign io_nxt   = valid & io_win & ~cfg_win;
  assign none_nxt = ordinary & (raw_hit == '0);

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter bit          ALT_MAP  = 1'b0,
  parameter logic [31:0] IO_BASE  = 32'hFFF0_0000,
  parameter int unsigned IO_LOG2  = 20,
  parameter logic [31:0] CFG_BASE = 32'hFFFF_F000,
  parameter int unsigned CFG_LOG2 = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [31:0]                   req_addr,
  output logic [adec_pkg::NUM_SLV-1:0]  slv_sel,
  output logic                          io_hit,
  output logic                          cfg_hit,
  output logic                          no_slave
);
  import adec_pkg::*;

  localparam int unsigned NS = NUM_SLV;

  // Configuration window must sit wholly inside the I/O window
  initial begin
    assert (CFG_LOG2 <= IO_LOG2 && in_span(CFG_BASE, IO_BASE, IO_LOG2))
      else $error("addr_window_decoder: config window outside I/O window");
  end

  // Named internal events, brought out for the checker
  logic [NS-1:0] raw_hit;
  logic          io_win;
  logic          cfg_win;

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_slv
      localparam logic [31:0] SB = map_base(ALT_MAP, s);
      localparam int unsigned SL = map_log2(ALT_MAP, s);
      adec_window #(.BASE(SB), .LOG2(SL)) u_win (
        .addr (req_addr),
        .hit  (raw_hit[s])
      );
    end
  endgenerate

  adec_window #(.BASE(IO_BASE), .LOG2(IO_LOG2)) u_io_win (
    .addr (req_addr),
    .hit  (io_win)
  );

  adec_window #(.BASE(CFG_BASE), .LOG2(CFG_LOG2)) u_cfg_win (
    .addr (req_addr),
    .hit  (cfg_win)
  );

  logic [NS-1:0] sel_nxt;
  logic          io_nxt, cfg_nxt, none_nxt;

  adec_resolve #(.N(NS)) u_resolve (
    .valid    (req_valid),
    .raw_hit  (raw_hit),
    .io_win   (io_win),
    .cfg_win  (cfg_win),
    .sel_nxt  (sel_nxt),
    .io_nxt   (io_nxt),
    .cfg_nxt  (cfg_nxt),
    .none_nxt (none_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slv_sel  <= '0;
      io_hit   <= 1'b0;
      cfg_hit  <= 1'b0;
      no_slave <= 1'b0;
    end else begin
      slv_sel  <= sel_nxt;
      io_hit   <= io_nxt;
      cfg_hit  <= cfg_nxt;
      no_slave <= none_nxt;
    end
  end

endmodule

// File: rtl/adec_checker.sv
module adec_checker #(
  parameter int unsigned NUM_SLV = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [NUM_SLV-1:0] raw_hit,
  input logic               io_win,
  input logic               cfg_win,
  input logic [NUM_SLV-1:0] slv_sel,
  input logic               io_hit,
  input logic               cfg_hit,
  input logic               no_slave
);
  // One full cycle out of reset before any $past is trusted
  logic primed;
  always_ff @(posedge clk) primed <= rst_n;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $onehot0(slv_sel)); // R9

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(req_valid) |-> $countones({slv_sel, io_hit, cfg_hit, no_slave}) == 1); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !$past(req_valid) |-> ({slv_sel, io_hit, cfg_hit, no_slave} == '0)); // R7

  AST_CFG_SHADOW: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(req_valid && cfg_win) |-> (cfg_hit && !io_hit && slv_sel == '0)); // R4

  AST_IO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(req_valid && io_win && !cfg_win) |-> (io_hit && slv_sel == '0)); // R5

  AST_NO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(req_valid && !io_win && raw_hit == '0) |-> no_slave); // R6

  AST_SEL_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (slv_sel & ~$past(raw_hit)) == '0); // R1

endmodule

bind addr_window_decoder adec_checker #(.NUM_SLV(adec_pkg::NUM_SLV)) u_adec_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .raw_hit   (raw_hit),
  .io_win    (io_win),
  .cfg_win   (cfg_win),
  .slv_sel   (slv_sel),
  .io_hit    (io_hit),
  .cfg_hit   (cfg_hit),
  .no_slave  (no_slave)
);

// File: tb/addr_window_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_window_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;

  logic [4:0] sel_d, sel_a;
  logic       io_d, io_a, cfg_d, cfg_a, none_d, none_a;

  always #4 clk = ~clk;  // 125 MHz

  addr_window_decoder #(.ALT_MAP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .slv_sel(sel_d), .io_hit(io_d), .cfg_hit(cfg_d), .no_slave(none_d));

  addr_window_decoder #(.ALT_MAP(1'b1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .slv_sel(sel_a), .io_hit(io_a), .cfg_hit(cfg_a), .no_slave(none_a));

  int n_chk = 0;
  int n_fail = 0;

  // Packed result: [4:0] selects, [5] io, [6] cfg, [7] no-slave
  function automatic logic [7:0] top_windows(input logic [31:0] a);
    if (a >= 32'hFFFF_F000) return 8'h40;
    if (a >= 32'hFFF0_0000) return 8'h20;
    return 8'h00;
  endfunction

  function automatic logic [7:0] want_default(input logic [31:0] a, input logic v);
    if (!v) return 8'h00;
    if (top_windows(a) != 8'h00) return top_windows(a);
    if (a <= 32'h1FFF_FFFF) return 8'h01;
    if (a >= 32'h4000_0000 && a <= 32'h7FFF_FFFF) return 8'h02;
    if (a >= 32'h8000_0000 && a <= 32'h8FFF_FFFF) return 8'h04;
    if (a >= 32'h9000_0000 && a <= 32'h9FFF_FFFF) return 8'h08;
    if (a >= 32'hF000_0000) return 8'h10;
    return 8'h80;
  endfunction

  function automatic logic [7:0] want_alt(input logic [31:0] a, input logic v);
    if (!v) return 8'h00;
    if (top_windows(a) != 8'h00) return top_windows(a);
    if (a <= 32'h7FFF_FFFF) return 8'h01;
    if (a <= 32'hBFFF_FFFF) return 8'h02;
    if (a <= 32'hCFFF_FFFF) return 8'h04;
    if (a <= 32'hDFFF_FFFF) return 8'h08;
    if (a <= 32'hEFFF_FFFF) return 8'h10;
    return 8'h80;
  endfunction

  typedef struct {
    string       tag;
    logic [31:0] addr;
    logic [7:0]  exp_d;
    logic [7:0]  exp_a;
  } item_t;

  item_t sb_q[$];

  task automatic check8(input string tag, input string what, input logic [31:0] a,
                        input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, a, got, exp);
    end
  endtask

  // Driver: present one transfer, push what both instances must show
  task automatic send(input logic [31:0] a, input logic v, input string tag);
    item_t it;
    @(negedge clk);
    req_addr  = a;
    req_valid = v;
    it.tag   = tag;
    it.addr  = a;
    it.exp_d = want_default(a, v);
    it.exp_a = want_alt(a, v);
    sb_q.push_back(it);
  endtask

  // Monitor: the result of the previous negedge's inputs lands at this posedge (R8)
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check8(it.tag, "default-map", it.addr, {none_d, cfg_d, io_d, sel_d}, it.exp_d);
      check8(it.tag, "alt-map(R3)", it.addr, {none_a, cfg_a, io_a, sel_a}, it.exp_a);
    end
  end

  initial begin
    #800us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // Drive a hitting address during reset: outputs must stay clear (R8)
    req_valid = 1'b1;
    req_addr  = 32'h4000_0000;
    repeat (4) @(posedge clk);
    #2;
    check8("R8", "reset-default", req_addr, {none_d, cfg_d, io_d, sel_d}, 8'h00);
    check8("R8", "reset-alt", req_addr, {none_a, cfg_a, io_a, sel_a}, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check8("R8", "post-reset", req_addr, {none_d, cfg_d, io_d, sel_d}, 8'h00);

    // Region edges, default map (R1, R2)
    send(32'h0000_0000, 1'b1, "R2");
    send(32'h1FFF_FFFF, 1'b1, "R1");
    send(32'h2000_0000, 1'b1, "R1");
    send(32'h3FFF_FFFF, 1'b1, "R6");
    send(32'h4000_0000, 1'b1, "R2");
    send(32'h7FFF_FFFF, 1'b1, "R1");
    send(32'h8000_0000, 1'b1, "R2");
    send(32'h8FFF_FFFF, 1'b1, "R1");
    send(32'h9000_0000, 1'b1, "R2");
    send(32'h9FFF_FFFF, 1'b1, "R1");
    send(32'hA000_0000, 1'b1, "R6");
    send(32'hEFFF_FFFF, 1'b1, "R6");
    send(32'hF000_0000, 1'b1, "R2");
    send(32'hFFEF_FFFF, 1'b1, "R1");
    // Alternate map edges (R3)
    send(32'hBFFF_FFFF, 1'b1, "R3");
    send(32'hC000_0000, 1'b1, "R3");
    send(32'hDFFF_FFFF, 1'b1, "R3");
    send(32'hE000_0000, 1'b1, "R3");
    // Windows shadow the slave under them (R4, R5)
    send(32'hFFF0_0000, 1'b1, "R5");
    send(32'hFFFF_EFFF, 1'b1, "R5");
    send(32'hFFFF_F000, 1'b1, "R4");
    send(32'hFFFF_FFFF, 1'b1, "R4");
    // Strobe low gates everything (R7)
    send(32'h4000_0000, 1'b0, "R7");
    send(32'hFFFF_F000, 1'b0, "R7");
    send(32'hFFF4_0000, 1'b0, "R7");
    send(32'h0000_1000, 1'b1, "R8");
    send(32'hFFF0_0010, 1'b1, "R8");

    // Random stream, a quarter pushed into the top megabyte (R9)
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = $urandom;
      if ((k % 4) == 0) a = a | 32'hFFF0_0000;
      send(a, (k % 9) != 0, "R9");
    end

    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule